// File: doc/BRIEF.md
# Accumulator ALU with carry

This block is the arithmetic and logic unit of an 8-bit accumulator machine, with the machine's state registers built in. The accumulator is always the first operand and always takes the result. The caller supplies a second 8-bit operand and a function code. A companion pair register holds the high product byte after a multiply and the remainder after a divide. The block also keeps three flags: carry, auxiliary (nibble) carry and signed overflow.

Each function is computed combinationally from the registered state and the inputs. The registers take the new values on a clock edge only while the enable input is high. Two outputs are combinational and serve the caller within the same cycle:
- the value to be written back to the operand's location, for the two exchange functions;
- a not-equal indication for the compare, used to decide a branch.

Top module: `acc_alu_core`

## Requirements
- R1: After reset, the accumulator, the pair register and all three flags are zero.
- R2: With `en_i` low, no state changes. Function codes 20 to 31 are no-operations and leave every state bit unchanged.
- R3: Code 0 adds the operand to A. Code 1 also adds the carry flag. Carry takes the carry out of bit 7, the auxiliary flag takes the carry out of bit 3, and overflow is set when the signed two's-complement sum leaves the range -128..127.
- R4: Code 2 computes A minus the operand minus the carry flag. Carry takes the borrow out of bit 7, the auxiliary flag takes the borrow out of bit 3, and overflow flags a signed result outside -128..127.
- R5: Code 3 (compare) sets carry when A is less than the operand as unsigned numbers and clears it otherwise. It leaves A, the pair register, the auxiliary flag and overflow unchanged. `neq_o` is high exactly when the code is 3 and A differs from the operand.
- R6: Code 4 writes the 16-bit product A times the pair register: the high byte goes to the pair register and the low byte to A. It clears carry and sets overflow exactly when the product exceeds 255.
- R7: Code 5 with a nonzero pair register puts the unsigned quotient A / pair into A and the remainder into the pair register, and clears carry and overflow.
- R8: Code 5 with the pair register at zero sets overflow, clears carry, and leaves A and the pair register unchanged.
- R9: Code 6 (decimal adjust) works in two steps.
  - First, it adds 06h when A's low nibble exceeds 9 or the auxiliary flag is set.
  - Then, it adds 60h when the high nibble of that intermediate result exceeds 9, or when carry is set, or when the first step carried out of bit 7.
  - Carry is set if either step carries out of bit 7 and otherwise keeps its value.
- R10: Codes 7, 8 and 9 replace A with A AND, OR and XOR the operand. Code 10 clears A and code 11 inverts it. None of these changes a flag.
- R11: Codes 12 and 13 rotate A left and right by one bit. Codes 14 and 15 rotate the 9-bit ring of carry and A left and right, where carry is the bit above bit 7. Only codes 14 and 15 change a flag.
- R12: Code 16 swaps the two nibbles of A. Code 17 exchanges A bits 3..0 with operand bits 3..0. Code 18 exchanges all of A with the operand. Code 19 exchanges A with the pair register. For codes 17 and 18, `opnd_o` carries the new operand value; for every other code it equals `opnd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Commit the function result on this edge |
| op_i | input | 5 | Function code |
| opnd_i | input | 8 | Second operand |
| acc_o | output | 8 | Accumulator register |
| pair_o | output | 8 | Pair register (product high byte, remainder) |
| cy_o | output | 1 | Carry flag |
| ac_o | output | 1 | Auxiliary carry flag (bit 3) |
| ov_o | output | 1 | Overflow flag |
| opnd_o | output | 8 | Operand write-back value for the exchange codes |
| neq_o | output | 1 | Compare found A and operand unequal |

## Verification
Carry-chained add and borrowed subtract are swept over every operand against a grid of accumulator values. A wrong carry-in selection, borrow polarity or bit-3 tap would show up at once as a wrong flag at the nibble and byte wrap points. Multiply and divide are swept over a grid that includes a zero divisor and a zero multiplier. A divider that writes on a zero divisor, or a multiply that misses the overflow threshold at 256, would corrupt A or the flag. Decimal adjust is run after every sum of packed decimal pairs, including pairs whose sum crosses 99. There, a missing second correction or a carry lost between the two steps leaves a non-decimal digit. The rotate-through-carry codes, disabled cycles and unused codes are checked to show that nothing beyond their defined bits moves.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD     = 5'd0,
        OP_ADD_C   = 5'd1,
        OP_SUB_B   = 5'd2,
        OP_CMP     = 5'd3,
        OP_MUL     = 5'd4,
        OP_DIV     = 5'd5,
        OP_DEC_ADJ = 5'd6,
        OP_AND     = 5'd7,
        OP_OR      = 5'd8,
        OP_XOR     = 5'd9,
        OP_ZERO    = 5'd10,
        OP_INV     = 5'd11,
        OP_ROL     = 5'd12,
        OP_ROR     = 5'd13,
        OP_ROLC    = 5'd14,
        OP_RORC    = 5'd15,
        OP_NSWAP   = 5'd16,
        OP_LOXCH   = 5'd17,
        OP_XCH     = 5'd18,
        OP_XPAIR   = 5'd19
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] pair;
        logic          cy;
        logic          ac;
        logic          ov;
    } alu_state_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W  = 8,
    parameter int HW = W / 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] x,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         c_out,
    output logic         h_out,
    output logic         v_out
);
    logic [W-1:0] xe;
    logic         ce;
    logic [W:0]   full;
    logic [HW:0]  half;

    always_comb begin
        // Subtract as a + ~x + ~borrow_in; carry out inverted is the borrow.
        xe    = sub ? ~x : x;
        ce    = sub ? ~cin : cin;
        full  = {1'b0, a} + {1'b0, xe} + {{W{1'b0}}, ce};
        half  = {1'b0, a[HW-1:0]} + {1'b0, xe[HW-1:0]} + {{HW{1'b0}}, ce};
        res   = full[W-1:0];
        c_out = full[W] ^ sub;
        h_out = half[HW] ^ sub;
        v_out = (a[W-1] == xe[W-1]) && (full[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] d,
    output logic [W-1:0] prod_lo,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] quo,
    output logic [W-1:0] rmd,
    output logic         dzero
);
    logic [2*W-1:0] prod;
    logic [W-1:0]   rem_s [0:W];

    assign prod    = {{W{1'b0}}, a} * {{W{1'b0}}, d};
    assign prod_lo = prod[W-1:0];
    assign prod_hi = prod[2*W-1:W];
    assign dzero   = (d == '0);

    // Restoring division, one stage per quotient bit, most significant first.
    assign rem_s[0] = '0;
    for (genvar i = 0; i < W; i++) begin : g_stage
        logic [W:0] shifted;
        logic [W:0] trial;
        assign shifted           = {rem_s[i], a[W-1-i]};
        assign trial             = shifted - {1'b0, d};
        assign quo[W-1-i]        = ~trial[W];
        assign rem_s[i+1]        = trial[W] ? shifted[W-1:0] : trial[W-1:0];
    end
    assign rmd = rem_s[W];
endmodule

// File: rtl/alu_decadj.sv
module alu_decadj #(
    parameter int W  = 8,
    parameter int HW = W / 2
) (
    input  logic [W-1:0] a,
    input  logic         cy,
    input  logic         ac,
    output logic [W-1:0] res,
    output logic         cy_out
);
    localparam logic [W:0]    LO_ADJ = (W+1)'(6);
    localparam logic [W:0]    HI_ADJ = LO_ADJ << HW;
    localparam logic [HW-1:0] DMAX   = HW'(9);

    logic [W:0] t1;
    logic [W:0] t2;
    logic       c1;

    always_comb begin
        t1     = {1'b0, a} + (((a[HW-1:0] > DMAX) || ac) ? LO_ADJ : '0);
        c1     = cy | t1[W];
        t2     = {1'b0, t1[W-1:0]} + (((t1[W-1:HW] > DMAX) || c1) ? HI_ADJ : '0);
        res    = t2[W-1:0];
        cy_out = c1 | t2[W];
    end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int W  = 8,
    parameter int HW = W / 2
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] x,
    input  logic         cy,
    output logic [W-1:0] res,
    output logic         cy_out,
    output logic [W-1:0] x_out
);
    always_comb begin
        res    = a;
        cy_out = cy;
        x_out  = x;
        unique case (op)
            OP_AND:   res = a & x;
            OP_OR:    res = a | x;
            OP_XOR:   res = a ^ x;
            OP_ZERO:  res = '0;
            OP_INV:   res = ~a;
            OP_ROL:   res = {a[W-2:0], a[W-1]};
            OP_ROR:   res = {a[0], a[W-1:1]};
            OP_ROLC: begin
                res    = {a[W-2:0], cy};
                cy_out = a[W-1];
            end
            OP_RORC: begin
                res    = {cy, a[W-1:1]};
                cy_out = a[0];
            end
            OP_NSWAP: res = {a[HW-1:0], a[W-1:HW]};
            OP_LOXCH: begin
                res   = {a[W-1:HW], x[HW-1:0]};
                x_out = {x[W-1:HW], a[HW-1:0]};
            end
            OP_XCH: begin
                res   = x;
                x_out = a;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic [OPW-1:0] op_i,
    input  logic [DW-1:0]  opnd_i,
    output logic [DW-1:0]  acc_o,
    output logic [DW-1:0]  pair_o,
    output logic           cy_o,
    output logic           ac_o,
    output logic           ov_o,
    output logic [DW-1:0]  opnd_o,
    output logic           neq_o
);
    alu_op_e    op;
    alu_state_t st_q, st_d;

    logic          as_sub, as_cin, as_c, as_h, as_v;
    logic [DW-1:0] as_res;
    logic [DW-1:0] md_plo, md_phi, md_quo, md_rmd;
    logic          md_dz;
    logic [DW-1:0] da_res;
    logic          da_cy;
    logic [DW-1:0] bo_res, bo_xo;
    logic          bo_cy;

    assign op     = alu_op_e'(op_i);
    assign as_sub = (op == OP_SUB_B) || (op == OP_CMP);
    assign as_cin = ((op == OP_ADD_C) || (op == OP_SUB_B)) ? st_q.cy : 1'b0;

    alu_addsub #(.W(DW), .HW(NW)) u_addsub (
        .a(st_q.acc), .x(opnd_i), .cin(as_cin), .sub(as_sub),
        .res(as_res), .c_out(as_c), .h_out(as_h), .v_out(as_v)
    );

    alu_muldiv #(.W(DW)) u_muldiv (
        .a(st_q.acc), .d(st_q.pair),
        .prod_lo(md_plo), .prod_hi(md_phi),
        .quo(md_quo), .rmd(md_rmd), .dzero(md_dz)
    );

    alu_decadj #(.W(DW), .HW(NW)) u_decadj (
        .a(st_q.acc), .cy(st_q.cy), .ac(st_q.ac),
        .res(da_res), .cy_out(da_cy)
    );

    alu_bitops #(.W(DW), .HW(NW)) u_bitops (
        .op(op), .a(st_q.acc), .x(opnd_i), .cy(st_q.cy),
        .res(bo_res), .cy_out(bo_cy), .x_out(bo_xo)
    );

    always_comb begin
        st_d   = st_q;
        opnd_o = opnd_i;
        neq_o  = 1'b0;
        unique case (op)
            OP_ADD, OP_ADD_C, OP_SUB_B: begin
                st_d.acc = as_res;
                st_d.cy  = as_c;
                st_d.ac  = as_h;
                st_d.ov  = as_v;
            end
            OP_CMP: begin
                st_d.cy = as_c;
                neq_o   = (as_res != '0);
            end
            OP_MUL: begin
                st_d.acc  = md_plo;
                st_d.pair = md_phi;
                st_d.cy   = 1'b0;
                st_d.ov   = (md_phi != '0);
            end
            OP_DIV: begin
                st_d.cy = 1'b0;
                st_d.ov = md_dz;
                if (!md_dz) begin
                    st_d.acc  = md_quo;
                    st_d.pair = md_rmd;
                end
            end
            OP_DEC_ADJ: begin
                st_d.acc = da_res;
                st_d.cy  = da_cy;
            end
            OP_AND, OP_OR, OP_XOR, OP_ZERO, OP_INV, OP_ROL, OP_ROR,
            OP_ROLC, OP_RORC, OP_NSWAP, OP_LOXCH, OP_XCH: begin
                st_d.acc = bo_res;
                st_d.cy  = bo_cy;
                opnd_o   = bo_xo;
            end
            OP_XPAIR: begin
                st_d.acc  = st_q.pair;
                st_d.pair = st_q.acc;
            end
            default: ;
        endcase
        if (!en_i) begin
            st_d = st_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o  = st_q.acc;
    assign pair_o = st_q.pair;
    assign cy_o   = st_q.cy;
    assign ac_o   = st_q.ac;
    assign ov_o   = st_q.ov;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           en_i,
    input logic [OPW-1:0] op_i,
    input logic [DW-1:0]  opnd_i,
    input logic [DW-1:0]  acc_o,
    input logic [DW-1:0]  pair_o,
    input logic           cy_o,
    input logic           ac_o,
    input logic           ov_o,
    input logic [DW-1:0]  opnd_o,
    input logic           neq_o
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(acc_o) && $stable(pair_o) && $stable(cy_o)
                  && $stable(ac_o) && $stable(ov_o));

    p_cmp_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == OP_CMP) |=> acc_o == $past(acc_o)
            && cy_o == ($past(acc_o) < $past(opnd_i)));

    p_neq_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_CMP) |-> !neq_o);

    p_mul_prod_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == OP_MUL) |=> !cy_o
            && {pair_o, acc_o} == (16'($past(acc_o)) * 16'($past(pair_o))));

    p_div_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == OP_DIV && pair_o != '0) |=> !ov_o && !cy_o
            && pair_o < $past(pair_o)
            && (16'(acc_o) * 16'($past(pair_o)) + 16'(pair_o)) == 16'($past(acc_o)));

    p_div_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == OP_DIV && pair_o == '0) |=> ov_o && !cy_o
            && acc_o == $past(acc_o) && pair_o == $past(pair_o));

    p_logic_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i >= OP_AND && op_i <= OP_INV) |=>
            $stable(cy_o) && $stable(ac_o) && $stable(ov_o));

    p_nswap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == OP_NSWAP) |=>
            acc_o == {$past(acc_o[NW-1:0]), $past(acc_o[DW-1:NW])});

    p_loxch_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LOXCH) |-> opnd_o == {opnd_i[DW-1:NW], acc_o[NW-1:0]});
endmodule

bind acc_alu_core acc_alu_chk u_chk (.*);

// File: tb/tb_acc_alu_core.sv
`timescale 1ns/1ps
module tb_acc_alu_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] opnd_i = '0;
    logic [7:0] acc_o, pair_o, opnd_o;
    logic       cy_o, ac_o, ov_o, neq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int ma = 0, mb = 0, mc = 0, mac = 0, mov = 0;

    always #4 clk = ~clk;

    acc_alu_core dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i), .opnd_i(opnd_i),
        .acc_o(acc_o), .pair_o(pair_o), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o),
        .opnd_o(opnd_o), .neq_o(neq_o)
    );

    function automatic int sgn(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic int bcd(input int v);
        return (v / 10) * 16 + (v % 10);
    endfunction

    task automatic check_state(input string req);
        n_chk++;
        if (acc_o !== ma[7:0] || pair_o !== mb[7:0] || cy_o !== mc[0]
            || ac_o !== mac[0] || ov_o !== mov[0]) begin
            n_bad++;
            $display("FAIL %s: acc/pair/cy/ac/ov actual %h/%h/%b/%b/%b expected %h/%h/%0d/%0d/%0d",
                     req, acc_o, pair_o, cy_o, ac_o, ov_o, ma[7:0], mb[7:0], mc, mac, mov);
        end
    endtask

    // Apply one enabled function and compare against the arithmetic model.
    task automatic run(input int code, input int x, input string req);
        int na = ma, nb = mb, nc = mc, nac = mac, nov = mov;
        int exo = x, eneq = 0, s, lo, t, p;
        case (code)
            0, 1: begin
                int ci = (code == 1) ? mc : 0;
                s = ma + x + ci; lo = (ma % 16) + (x % 16) + ci;
                na = s % 256; nc = (s > 255); nac = (lo > 15);
                s = sgn(ma) + sgn(x) + ci; nov = (s > 127 || s < -128);
            end
            2: begin
                s = ma - x - mc; lo = (ma % 16) - (x % 16) - mc;
                na = (s + 256) % 256; nc = (s < 0); nac = (lo < 0);
                s = sgn(ma) - sgn(x) - mc; nov = (s > 127 || s < -128);
            end
            3: begin nc = (ma < x); eneq = (ma != x); end
            4: begin p = ma * mb; na = p % 256; nb = p / 256; nc = 0; nov = (p > 255); end
            5: begin
                nc = 0;
                if (mb == 0) nov = 1;
                else begin na = ma / mb; nb = ma % mb; nov = 0; end
            end
            6: begin
                t = ma;
                if ((t % 16) > 9 || mac != 0) t = t + 6;
                if (t > 255) nc = 1;
                if (((t % 256) / 16) > 9 || nc != 0) t = (t % 256) + 96;
                if (t > 255) nc = 1;
                na = t % 256;
            end
            7:  na = ma & x;
            8:  na = ma | x;
            9:  na = ma ^ x;
            10: na = 0;
            11: na = 255 - ma;
            12: na = ((ma * 2) % 256) | (ma / 128);
            13: na = (ma / 2) | ((ma % 2) * 128);
            14: begin na = ((ma * 2) % 256) | mc; nc = ma / 128; end
            15: begin na = (ma / 2) | (mc * 128); nc = ma % 2; end
            16: na = (ma % 16) * 16 + ma / 16;
            17: begin na = (ma / 16) * 16 + x % 16; exo = (x / 16) * 16 + ma % 16; end
            18: begin na = x; exo = ma; end
            19: begin na = mb; nb = ma; end
            default: ;
        endcase
        @(negedge clk);
        op_i = code[4:0]; opnd_i = x[7:0]; en_i = 1'b1;
        #1;
        if (opnd_o !== exo[7:0] || neq_o !== eneq[0]) begin
            n_bad++; n_chk++;
            $display("FAIL %s: opnd_o/neq_o actual %h/%b expected %h/%0d (code %0d)",
                     req, opnd_o, neq_o, exo[7:0], eneq, code);
        end
        @(posedge clk); #1;
        ma = na; mb = nb; mc = nc; mac = nac; mov = nov;
        check_state(req);
    endtask

    task automatic idle;
        @(negedge clk);
        en_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_state("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R3 R4 R5: grid of A against every operand
        for (int a = 0; a < 256; a += 15) begin
            for (int x = 0; x < 256; x++) begin
                run(18, a, "R12");
                run(0, x, "R3");
                run(18, a, "R12");
                run(1, x, "R3");
                run(18, a, "R12");
                run(2, x, "R4");
                run(3, x, "R5");
                run(3, a, "R5");
            end
        end

        // R6 R7 R8: multiply and divide grid, zero included
        for (int a = 0; a < 256; a += 13) begin
            for (int b = 0; b < 256; b += 17) begin
                run(18, b, "R12");
                run(19, 0, "R12");
                run(18, a, "R12");
                run(4, 0, "R6");
                run(18, b, "R12");
                run(19, 0, "R12");
                run(18, a, "R12");
                run(5, 0, (b == 0) ? "R8" : "R7");
            end
        end

        // R9: decimal adjust after packed decimal sums
        for (int i = 0; i < 100; i++) begin
            for (int j = 0; j < 100; j += 3) begin
                run(18, bcd(i), "R12");
                run(0, bcd(j), "R3");
                run(6, 0, "R9");
            end
        end

        // R10 R11 R12: logic, rotates and swaps
        for (int a = 0; a < 256; a += 7) begin
            for (int x = 0; x < 256; x += 11) begin
                for (int c = 7; c <= 17; c++) begin
                    run(18, a, "R12");
                    run(c, x, (c <= 11) ? "R10" : (c <= 15) ? "R11" : "R12");
                end
            end
        end

        // R2: disabled cycles and unused codes
        run(18, 8'h5a, "R12");
        run(14, 0, "R11");
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            en_i = 1'b0; op_i = 5'(k); opnd_i = 8'h3c;
            @(posedge clk); #1;
            check_state("R2");
        end
        for (int c = 20; c < 32; c++) run(c, 8'hc3, "R2");
        idle();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule